// File: doc/BRIEF.md
# Battery-Backed SRAM Access Guard

This block wraps a small synchronous byte-wide RAM array and decides, on every clock, whether an access from the host port may reach it. An external supply comparator reports a digital power-good level. While that level is low, the guard treats the RAM as fully deselected. It accepts no writes, stops driving data and ignores every address, data and control input. Supply sensing, battery switch-over and voltage thresholds are outside the block and reach it only as input levels.

A second input reports whether the backup battery is weak. The guard samples it once each time supply power returns. If the battery was weak at that moment, a lockout flag is set. The next write attempt is then swallowed, and that attempt also clears the flag. Host firmware can use this to detect a weak battery: it reads a byte, writes back its complement, and reads the byte again. If the byte has not changed, the battery was low. The flag is also visible on a status output.

The host data bus is bidirectional at the pad. Inside the chip it is carried as a separate input, a separate output and an output enable. The output enable low stands for high impedance.

Top module: `bbsram_guard`

## Requirements
- R1: After reset the lockout flag is 0, and `data_oe_o` stays 0 until power-good has been seen, even with a read presented.
- R2: `pwr_good_i` is synchronized. Accesses open, and the flag takes its new value, at the third rising clock edge after `pwr_good_i` goes high. After only two edges, a presented read still gives `data_oe_o` = 0 and the flag keeps its old value.
- R3: While power is not good, no write changes the array contents.
- R4: While power is not good, `data_oe_o` is 0 whatever `cs_i`, `we_i` and `oe_i` are.
- R5: While power is not good, write attempts and other inputs leave `batt_flag_o` unchanged.
- R6: At the power-return edge of R2, the flag is loaded with the value of `batt_low_i` at that moment (1 = weak battery).
- R7: With the flag set, the first write attempt does not change the array, and the flag reads 0 from the following cycle on.
- R8: Once the flag has cleared, later writes store their data normally.
- R9: Reads work while the flag is set, and a read does not clear the flag.
- R10: A write is a cycle with `cs_i`=1 and `we_i`=1 and is stored at that clock edge. A read is a cycle with `cs_i`=1 and `we_i`=0. Its data is registered and appears on `data_o` in the following cycle while `cs_i`=1, `oe_i`=1 and `we_i`=0. `data_oe_o` is 1 exactly under those three conditions with power good, and `data_o` is 0 otherwise.
- R11: A cycle with `we_i`=1 but `cs_i`=0 is not a write attempt and leaves the flag set.
- R12: Changes on `batt_low_i` between power-return edges have no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good_i | input | 1 | Supply in window, asynchronous level (1 = good) |
| batt_low_i | input | 1 | Backup battery weak (1 = weak), sampled at power return |
| cs_i | input | 1 | Chip select, active high |
| we_i | input | 1 | Write enable, active high |
| oe_i | input | 1 | Output enable, active high |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | DATA_W | Write data from the pad |
| data_o | output | DATA_W | Read data to the pad |
| data_oe_o | output | 1 | Pad drive enable (0 = high impedance) |
| batt_flag_o | output | 1 | Weak-battery write lockout flag |

## Verification
The assertions check the following on every cycle:
- While power is out, no write reaches the array and the pad is never driven.
- While power is out, the flag is stable except at the power-return edge, where it equals the sampled battery level.
- A locked-out write attempt never reaches the array and clears the flag one cycle later.
- The pad is driven only on a selected, output-enabled read.

Some behaviour only the directed scenarios can show:
- The three-edge opening latency after power returns.
- That array contents written before a power loss survive writes attempted during it.
- The complement-and-reread detection of a weak battery.
- That later battery changes have no effect on the flag.

// File: rtl/bbsram_guard_pkg.sv
package bbsram_guard_pkg;

  // A write attempt: selected with write enable high.
  function automatic logic is_write(input logic cs, input logic we);
    return cs & we;
  endfunction

  // A read: selected with write enable low.
  function automatic logic is_read(input logic cs, input logic we);
    return cs & ~we;
  endfunction

  // Pad drive enable for the host bus.
  function automatic logic drives_pad(input logic ok, input logic cs,
                                      input logic we, input logic oe);
    return ok & cs & oe & ~we;
  endfunction

  // Next value of the lockout flag.
  function automatic logic next_lock(input logic cur, input logic rise,
                                     input logic batt_low, input logic wr);
    if (rise)     return batt_low;
    else if (wr)  return 1'b0;
    else          return cur;
  endfunction

endpackage

// File: rtl/bbsram_pwr_sync.sv
module bbsram_pwr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good_i,
  output logic pwr_ok_o,
  output logic pwr_rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              ok_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pwr_good_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pwr_good_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b0;
    else        ok_q <= sync_q[STAGES-1];
  end

  assign pwr_ok_o   = ok_q;
  assign pwr_rise_o = sync_q[STAGES-1] & ~ok_q;
endmodule

// File: rtl/bbsram_batt_lock.sv
module bbsram_batt_lock
  import bbsram_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_rise_i,
  input  logic batt_low_i,
  input  logic wr_attempt_i,
  output logic lock_o,
  output logic wr_allow_o
);
  logic lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= next_lock(lock_q, pwr_rise_i, batt_low_i, wr_attempt_i);
  end

  assign lock_o     = lock_q;
  assign wr_allow_o = wr_attempt_i & ~lock_q;
endmodule

// File: rtl/bbsram_ram_array.sv
module bbsram_ram_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rd_q <= '0;
    else if (re_i) rd_q <= mem[addr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/bbsram_guard.sv
module bbsram_guard
  import bbsram_guard_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good_i,
  input  logic              batt_low_i,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic              oe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              batt_flag_o
);
  // Named internal events, also used by the bound checker.
  logic pwr_ok;
  logic pwr_rise;
  logic wr_attempt;
  logic rd_access;
  logic mem_we;
  logic [DATA_W-1:0] rd_data;

  bbsram_pwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good_i (pwr_good_i),
    .pwr_ok_o   (pwr_ok),
    .pwr_rise_o (pwr_rise)
  );

  // With power out, all host inputs are masked here.
  assign wr_attempt = pwr_ok & is_write(cs_i, we_i);
  assign rd_access  = pwr_ok & is_read(cs_i, we_i);

  bbsram_batt_lock u_lock (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_rise_i   (pwr_rise),
    .batt_low_i   (batt_low_i),
    .wr_attempt_i (wr_attempt),
    .lock_o       (batt_flag_o),
    .wr_allow_o   (mem_we)
  );

  bbsram_ram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (mem_we),
    .re_i    (rd_access),
    .addr_i  (addr_i),
    .wdata_i (data_i),
    .rdata_o (rd_data)
  );

  assign data_oe_o = drives_pad(pwr_ok, cs_i, we_i, oe_i);
  assign data_o    = data_oe_o ? rd_data : '0;
endmodule

// File: rtl/bbsram_guard_chk.sv
module bbsram_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_ok,
  input logic pwr_rise,
  input logic wr_attempt,
  input logic mem_we,
  input logic cs_i,
  input logic we_i,
  input logic oe_i,
  input logic batt_low_i,
  input logic data_oe_o,
  input logic batt_flag_o
);
  // R3
  no_write_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> !mem_we);

  // R4
  pad_quiet_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> !data_oe_o);

  // R5
  flag_hold_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_ok && !pwr_rise) |=> $stable(batt_flag_o));

  // R6
  flag_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_rise |=> (batt_flag_o == $past(batt_low_i)));

  // R7
  locked_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_flag_o && wr_attempt) |-> !mem_we);

  // R7
  flag_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_flag_o && wr_attempt) |=> !batt_flag_o);

  // R10
  pad_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> (cs_i && oe_i && !we_i));
endmodule

bind bbsram_guard bbsram_guard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_ok      (pwr_ok),
  .pwr_rise    (pwr_rise),
  .wr_attempt  (wr_attempt),
  .mem_we      (mem_we),
  .cs_i        (cs_i),
  .we_i        (we_i),
  .oe_i        (oe_i),
  .batt_low_i  (batt_low_i),
  .data_oe_o   (data_oe_o),
  .batt_flag_o (batt_flag_o)
);

// File: tb/bbsram_guard_bench.sv
module bbsram_guard_bench;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_good_i = 1'b0;
  logic          batt_low_i = 1'b0;
  logic          cs_i = 1'b0;
  logic          we_i = 1'b0;
  logic          oe_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic          data_oe_o;
  logic          batt_flag_o;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  bbsram_guard u_bbsram_guard (
    .clk(clk), .rst_n(rst_n), .pwr_good_i(pwr_good_i), .batt_low_i(batt_low_i),
    .cs_i(cs_i), .we_i(we_i), .oe_i(oe_i), .addr_i(addr_i), .data_i(data_i),
    .data_o(data_o), .data_oe_o(data_oe_o), .batt_flag_o(batt_flag_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present one access at a falling edge, let one rising edge pass,
  // and return at the next falling edge with the inputs still held.
  task automatic cyc(input logic cs, input logic we, input logic oe,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    cs_i = cs; we_i = we; oe_i = oe; addr_i = a; data_i = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic rd_check(input string req, input logic [AW-1:0] a,
                          input logic [DW-1:0] exp);
    cyc(1'b1, 1'b0, 1'b1, a, '0);
    check(req, int'(data_oe_o), 1);
    check(req, int'(data_o), int'(exp));
  endtask

  task automatic power_down();
    pwr_good_i = 1'b0;
    repeat (3) idle();
  endtask

  task automatic power_up(input logic batt);
    batt_low_i = batt;
    pwr_good_i = 1'b1;
    repeat (3) idle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b1, 1'b0, 1'b1, 8'h10, '0);
    check("R1 flag after reset", int'(batt_flag_o), 0);
    check("R1 no drive before power", int'(data_oe_o), 0);
  endtask

  task automatic t_power_up_timing();
    batt_low_i = 1'b1;
    pwr_good_i = 1'b1;
    cyc(1'b1, 1'b0, 1'b1, 8'h00, '0);
    cyc(1'b1, 1'b0, 1'b1, 8'h00, '0);
    check("R2 closed after two edges", int'(data_oe_o), 0);
    check("R2 flag old after two edges", int'(batt_flag_o), 0);
    cyc(1'b1, 1'b0, 1'b1, 8'h00, '0);
    check("R2 open after third edge", int'(data_oe_o), 1);
    check("R6 flag loaded weak", int'(batt_flag_o), 1);
    // consume the lockout so the array starts from known writes
    cyc(1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
    check("R7 flag cleared", int'(batt_flag_o), 0);
  endtask

  task automatic t_normal();
    cyc(1'b1, 1'b1, 1'b0, 8'h01, 8'hA5);
    cyc(1'b1, 1'b1, 1'b0, 8'h02, 8'h5A);
    cyc(1'b1, 1'b1, 1'b0, 8'hFF, 8'hC3);
    cyc(1'b1, 1'b1, 1'b1, 8'h40, 8'h3C);
    check("R10 no drive during write", int'(data_oe_o), 0);
    rd_check("R10 read 01", 8'h01, 8'hA5);
    rd_check("R10 read 02", 8'h02, 8'h5A);
    rd_check("R10 read FF", 8'hFF, 8'hC3);
    rd_check("R10 read 40", 8'h40, 8'h3C);
    cyc(1'b1, 1'b0, 1'b0, 8'h01, '0);
    check("R10 no drive without oe", int'(data_oe_o), 0);
    check("R10 data zero without oe", int'(data_o), 0);
    cyc(1'b0, 1'b0, 1'b1, 8'h01, '0);
    check("R10 no drive without cs", int'(data_oe_o), 0);
  endtask

  task automatic t_batt_low();
    power_down();
    power_up(1'b1);
    check("R6 flag set at power return", int'(batt_flag_o), 1);
    rd_check("R9 read while locked", 8'h01, 8'hA5);
    check("R9 read keeps flag", int'(batt_flag_o), 1);
    cyc(1'b0, 1'b1, 1'b0, 8'h01, 8'h11);
    check("R11 unselected write keeps flag", int'(batt_flag_o), 1);
    // complement-and-reread detection
    cyc(1'b1, 1'b1, 1'b0, 8'h01, 8'h5A);
    check("R7 flag clears after attempt", int'(batt_flag_o), 0);
    rd_check("R7 blocked write left data", 8'h01, 8'hA5);
    rd_check("R11 unselected write left data", 8'h01, 8'hA5);
    cyc(1'b1, 1'b1, 1'b0, 8'h01, 8'h5A);
    rd_check("R8 later write stored", 8'h01, 8'h5A);
    batt_low_i = 1'b1;
    idle();
    batt_low_i = 1'b0;
    idle();
    batt_low_i = 1'b1;
    idle();
    check("R12 battery change ignored", int'(batt_flag_o), 0);
  endtask

  task automatic t_power_fail();
    power_down();
    power_up(1'b1);
    check("R6 flag set again", int'(batt_flag_o), 1);
    power_down();
    check("R5 flag held after loss", int'(batt_flag_o), 1);
    cyc(1'b1, 1'b1, 1'b0, 8'h02, 8'h77);
    cyc(1'b1, 1'b1, 1'b1, 8'hFF, 8'h88);
    check("R5 writes while out keep flag", int'(batt_flag_o), 1);
    check("R4 no drive with we+oe", int'(data_oe_o), 0);
    cyc(1'b1, 1'b0, 1'b1, 8'h02, '0);
    check("R4 no drive on read", int'(data_oe_o), 0);
    check("R4 data zero on read", int'(data_o), 0);
    power_up(1'b0);
    check("R6 flag loaded good", int'(batt_flag_o), 0);
    rd_check("R3 contents kept 02", 8'h02, 8'h5A);
    rd_check("R3 contents kept FF", 8'hFF, 8'hC3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_power_up_timing();
    t_normal();
    t_batt_low();
    t_power_fail();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule